// File: doc/BRIEF.md
# Radio Power-Mode Sequencer

This block is the mode controller of a short-range radio transceiver. It advances on a 1 MHz tick (a one-cycle enable in the system clock domain). From pin levels, pin edges and two register enables it decides which power-saving, transmit or receive mode the chip is in. It then drives the chip-clear line, the oscillator enable, the demodulator multiplier enable, and the power controls of the receive path, the transmit path and the power amplifier. When the synthesizer is running, a programmable timer moves its loop filter from wide to narrow bandwidth. A bypass bit hands the five power controls straight to register bits, for bring-up.

The controller guards its sequences. A request that has no defined transition leaves the state unchanged. The amplifier is always switched off one tick before the transmit path. After a transmit burst the controller can turn around to receive through a single tick of idle.

Top module: `radio_mode_ctrl`

## Requirements
- R1: Out of reset the mode code is 0 (off). In mode 0, `chip_clr` is 1 and `osc_on`, `mult_on`, `rx_pwr`, `tx_pwr` and `pa_pwr` are 0 (bypass clear). While `pwr_on` is low the mode stays 0.
- R2: From mode 0, a tick with `pwr_on` high enters mode 1 (oscillator settle): `chip_clr` goes 0 and `osc_on` goes 1. Mode 1 lasts exactly XTAL_SETTLE ticks and is followed by mode 2 (hold). Mode 2 stays until a tick sees `xtal_en` high, then mode 3 (idle) follows.
- R3: The mode changes only on a clock edge where `tick_1us` is 1.
- R4: In idle, `tx_en` and `rx_en` both high is an illegal request and the mode stays 3. Idle never moves directly to modes 7, 8, 9 or 10.
- R5: Idle with `tx_en`=1 and `rx_en`=0 enters mode 6 (transmit arm). `tx_pwr` rises on the TX_PU_DLY-th tick after entry. `tx_en` low in modes 6 or 7 returns to idle.
- R6: In mode 6, a 0-to-1 change of `data_in` between two ticks, seen while `pkt_ctl` is low, enters mode 7 (data sync). An edge seen while `pkt_ctl` is high is ignored, and so is a level held high.
- R7: In mode 7, `pkt_ctl` high enters mode 8 with `pa_pwr`=1. The next tick enters mode 9 (transmit run).
- R8: In mode 9, `pkt_ctl` low enters mode 10: `pa_pwr`=0 while `tx_pwr` stays 1. One tick later the mode is idle and `tx_pwr`=0.
- R9: If `rx_en` is already high when idle is entered from mode 10, idle lasts one tick and mode 11 (receive settle) follows.
- R10: In mode 11, `mult_on`=1. `rx_pwr` rises on the RX_PU_DLY-th tick after entry, and mode 12 (receive run) follows one tick later. `rx_en` low in mode 11 or 12 returns to idle with `rx_pwr` and `mult_on` at 0.
- R11: Idle with `xtal_en` low enters mode 4 (sleep), where all power outputs including `osc_on` are 0 and `chip_clr` is 0. `xtal_en` high enters mode 5 (wake), with `osc_on`=1, and idle follows after exactly XTAL_SETTLE ticks.
- R12: A tick with `pwr_on` low forces mode 0 from any mode. It takes priority over every other request in the same tick.
- R13: With the synthesizer on (modes 6 to 12), `bw_narrow` rises `bw_dly_sel`×BW_STEP ticks after entry, and at once when the code is 0. It is 0 whenever the synthesizer is off.
- R14: With `bypass`=1, the outputs follow `byp_bits`: bit 4 drives `osc_on`, bit 3 `mult_on`, bit 2 `pa_pwr`, bit 1 `rx_pwr` and bit 0 `tx_pwr`, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | 1 MHz step enable |
| pwr_on | input | 1 | Power-up pin level |
| xtal_en | input | 1 | Crystal-enable pin level |
| data_in | input | 1 | Data pin, input direction |
| pkt_ctl | input | 1 | Packet-control pin level |
| rx_en | input | 1 | Receive enable register bit |
| tx_en | input | 1 | Transmit enable register bit |
| bw_dly_sel | input | 2 | Wide-bandwidth hold code (×BW_STEP ticks) |
| bypass | input | 1 | Register bits drive the power outputs |
| byp_bits | input | 5 | Bypass values {osc, mult, pa, rx, tx} |
| chip_clr | output | 1 | Chip-clear, high in off mode |
| osc_on | output | 1 | Oscillator enable |
| mult_on | output | 1 | Demodulator multiplier enable |
| rx_pwr | output | 1 | Receive-path power |
| tx_pwr | output | 1 | Transmit-path power |
| pa_pwr | output | 1 | Power amplifier power |
| bw_narrow | output | 1 | Synthesizer narrow-bandwidth select |
| mode_o | output | 4 | Current mode code |

## Verification
A loss of `pwr_on` can land on the same tick as a qualifying data edge in transmit arm. That tick would otherwise move the controller to data sync. The bench provokes this by presenting the rising edge and the falling power pin before one single tick. It judges the result by requiring mode 0 with `chip_clr` high, and not mode 7. The bandwidth switch and the receive-run entry also share ticks, so the narrow select is checked across that boundary at a fixed count from synthesizer start.

// File: rtl/radio_mode_pkg.sv
package radio_mode_pkg;

  typedef enum logic [3:0] {
    ST_OFF          = 4'd0,
    ST_PWRUP_SETTLE = 4'd1,
    ST_PWRUP_HOLD   = 4'd2,
    ST_IDLE         = 4'd3,
    ST_SLEEP        = 4'd4,
    ST_WAKE_SETTLE  = 4'd5,
    ST_TX_ARM       = 4'd6,
    ST_TX_SYNC      = 4'd7,
    ST_PA_ON        = 4'd8,
    ST_TX_RUN       = 4'd9,
    ST_PA_OFF       = 4'd10,
    ST_RX_SETTLE    = 4'd11,
    ST_RX_RUN       = 4'd12
  } rm_state_e;

  // Bit positions of the power control vector
  localparam int PW_TX   = 0;
  localparam int PW_RX   = 1;
  localparam int PW_PA   = 2;
  localparam int PW_MULT = 3;
  localparam int PW_OSC  = 4;
  localparam int PW_N    = 5;

  function automatic logic synth_active(rm_state_e s);
    return (s inside {ST_TX_ARM, ST_TX_SYNC, ST_PA_ON, ST_TX_RUN,
                      ST_PA_OFF, ST_RX_SETTLE, ST_RX_RUN});
  endfunction

endpackage

// File: rtl/radio_mode_seq.sv
module radio_mode_seq
  import radio_mode_pkg::*;
#(
  parameter int XTAL_SETTLE = 8,
  parameter int TX_PU_DLY   = 4,
  parameter int RX_PU_DLY   = 6,
  localparam int M1     = (XTAL_SETTLE > TX_PU_DLY) ? XTAL_SETTLE : TX_PU_DLY,
  localparam int DW_MAX = (M1 > RX_PU_DLY) ? M1 : RX_PU_DLY,
  localparam int DW_W   = $clog2(DW_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            pwr_on_i,
  input  logic            xtal_en_i,
  input  logic            data_i,
  input  logic            pkt_i,
  input  logic            rx_en_i,
  input  logic            tx_en_i,
  output rm_state_e       st_o,
  output logic [DW_W-1:0] dwell_o
);

  localparam logic [DW_W-1:0] SETTLE_LIM = DW_W'(XTAL_SETTLE - 1);
  localparam logic [DW_W-1:0] RX_LIM     = DW_W'(RX_PU_DLY);
  localparam logic [DW_W-1:0] DW_SAT     = DW_W'(DW_MAX);

  rm_state_e       st_q, st_nxt;
  logic [DW_W-1:0] dwell_q, dwell_nxt;
  logic            data_q;
  logic            data_rise;
  logic            settle_done;

  assign data_rise   = data_i & ~data_q;
  assign settle_done = (dwell_q >= SETTLE_LIM);

  // Next-state decision, evaluated only on a tick
  always_comb begin
    st_nxt = st_q;
    if (tick_i) begin
      if (!pwr_on_i) begin
        st_nxt = ST_OFF;
      end else begin
        case (st_q)
          ST_OFF:          st_nxt = ST_PWRUP_SETTLE;
          ST_PWRUP_SETTLE: if (settle_done) st_nxt = ST_PWRUP_HOLD;
          ST_PWRUP_HOLD:   if (xtal_en_i) st_nxt = ST_IDLE;
          ST_IDLE: begin
            if (!xtal_en_i)                st_nxt = ST_SLEEP;
            else if (tx_en_i && !rx_en_i)  st_nxt = ST_TX_ARM;
            else if (rx_en_i && !tx_en_i)  st_nxt = ST_RX_SETTLE;
          end
          ST_SLEEP:        if (xtal_en_i) st_nxt = ST_WAKE_SETTLE;
          ST_WAKE_SETTLE:  if (settle_done) st_nxt = ST_IDLE;
          ST_TX_ARM: begin
            if (!tx_en_i)                  st_nxt = ST_IDLE;
            else if (data_rise && !pkt_i)  st_nxt = ST_TX_SYNC;
          end
          ST_TX_SYNC: begin
            if (!tx_en_i)                  st_nxt = ST_IDLE;
            else if (pkt_i)                st_nxt = ST_PA_ON;
          end
          ST_PA_ON:        st_nxt = ST_TX_RUN;
          ST_TX_RUN:       if (!pkt_i) st_nxt = ST_PA_OFF;
          ST_PA_OFF:       st_nxt = ST_IDLE;
          ST_RX_SETTLE: begin
            if (!rx_en_i)                  st_nxt = ST_IDLE;
            else if (dwell_q >= RX_LIM)    st_nxt = ST_RX_RUN;
          end
          ST_RX_RUN:       if (!rx_en_i) st_nxt = ST_IDLE;
          default:         st_nxt = ST_OFF;
        endcase
      end
    end
  end

  // Ticks spent in the current state, saturating
  always_comb begin
    if (st_nxt != st_q)       dwell_nxt = '0;
    else if (dwell_q == DW_SAT) dwell_nxt = dwell_q;
    else                      dwell_nxt = dwell_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      dwell_q <= '0;
      data_q  <= 1'b0;
    end else if (tick_i) begin
      st_q    <= st_nxt;
      dwell_q <= dwell_nxt;
      data_q  <= data_i;
    end
  end

  assign st_o    = st_q;
  assign dwell_o = dwell_q;

endmodule

// File: rtl/radio_pwr_decode.sv
module radio_pwr_decode
  import radio_mode_pkg::*;
#(
  parameter int TX_PU_DLY = 4,
  parameter int RX_PU_DLY = 6,
  parameter int DW_W      = 4
) (
  input  rm_state_e       st_i,
  input  logic [DW_W-1:0] dwell_i,
  input  logic            bypass_i,
  input  logic [PW_N-1:0] byp_bits_i,
  output logic            chip_clr_o,
  output logic [PW_N-1:0] pwr_o
);

  localparam logic [DW_W-1:0] TX_LIM = DW_W'(TX_PU_DLY);
  localparam logic [DW_W-1:0] RX_LIM = DW_W'(RX_PU_DLY);

  logic [PW_N-1:0] fsm_pwr;

  always_comb begin
    fsm_pwr          = '0;
    fsm_pwr[PW_OSC]  = !(st_i inside {ST_OFF, ST_SLEEP});
    fsm_pwr[PW_MULT] = (st_i inside {ST_RX_SETTLE, ST_RX_RUN});
    fsm_pwr[PW_RX]   = ((st_i == ST_RX_SETTLE) && (dwell_i >= RX_LIM)) ||
                       (st_i == ST_RX_RUN);
    fsm_pwr[PW_TX]   = ((st_i == ST_TX_ARM) && (dwell_i >= TX_LIM)) ||
                       (st_i inside {ST_TX_SYNC, ST_PA_ON, ST_TX_RUN, ST_PA_OFF});
    fsm_pwr[PW_PA]   = (st_i inside {ST_PA_ON, ST_TX_RUN});
  end

  assign chip_clr_o = (st_i == ST_OFF);

  for (genvar g = 0; g < PW_N; g++) begin : g_byp_mux
    assign pwr_o[g] = bypass_i ? byp_bits_i[g] : fsm_pwr[g];
  end

endmodule

// File: rtl/radio_bw_timer.sv
module radio_bw_timer #(
  parameter int BW_STEP = 50,
  localparam int BW_MAX = 3 * BW_STEP,
  localparam int BW_W   = $clog2(BW_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       synth_on_i,
  input  logic [1:0] sel_i,
  output logic       narrow_o
);

  localparam logic [BW_W-1:0] LIM1 = BW_W'(BW_STEP);
  localparam logic [BW_W-1:0] LIM2 = BW_W'(2 * BW_STEP);
  localparam logic [BW_W-1:0] LIM3 = BW_W'(BW_MAX);

  logic [BW_W-1:0] cnt_q, cnt_nxt;
  logic [BW_W-1:0] lim;

  always_comb begin
    case (sel_i)
      2'd0:    lim = '0;
      2'd1:    lim = LIM1;
      2'd2:    lim = LIM2;
      default: lim = LIM3;
    endcase
  end

  always_comb begin
    if (!synth_on_i)                  cnt_nxt = '0;
    else if (tick_i && cnt_q != LIM3) cnt_nxt = cnt_q + 1'b1;
    else                              cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign narrow_o = synth_on_i && (cnt_q >= lim);

endmodule

// File: rtl/radio_mode_ctrl.sv
module radio_mode_ctrl
  import radio_mode_pkg::*;
#(
  parameter int XTAL_SETTLE = 8,
  parameter int TX_PU_DLY   = 4,
  parameter int RX_PU_DLY   = 6,
  parameter int BW_STEP     = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1us,
  input  logic       pwr_on,
  input  logic       xtal_en,
  input  logic       data_in,
  input  logic       pkt_ctl,
  input  logic       rx_en,
  input  logic       tx_en,
  input  logic [1:0] bw_dly_sel,
  input  logic       bypass,
  input  logic [4:0] byp_bits,
  output logic       chip_clr,
  output logic       osc_on,
  output logic       mult_on,
  output logic       rx_pwr,
  output logic       tx_pwr,
  output logic       pa_pwr,
  output logic       bw_narrow,
  output logic [3:0] mode_o
);

  localparam int M1     = (XTAL_SETTLE > TX_PU_DLY) ? XTAL_SETTLE : TX_PU_DLY;
  localparam int DW_MAX = (M1 > RX_PU_DLY) ? M1 : RX_PU_DLY;
  localparam int DW_W   = $clog2(DW_MAX + 1);

  rm_state_e       st;
  logic [DW_W-1:0] dwell;
  logic [PW_N-1:0] pwr;
  logic            synth_on;

  radio_mode_seq #(
    .XTAL_SETTLE (XTAL_SETTLE),
    .TX_PU_DLY   (TX_PU_DLY),
    .RX_PU_DLY   (RX_PU_DLY)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_1us),
    .pwr_on_i  (pwr_on),
    .xtal_en_i (xtal_en),
    .data_i    (data_in),
    .pkt_i     (pkt_ctl),
    .rx_en_i   (rx_en),
    .tx_en_i   (tx_en),
    .st_o      (st),
    .dwell_o   (dwell)
  );

  radio_pwr_decode #(
    .TX_PU_DLY (TX_PU_DLY),
    .RX_PU_DLY (RX_PU_DLY),
    .DW_W      (DW_W)
  ) u_dec (
    .st_i       (st),
    .dwell_i    (dwell),
    .bypass_i   (bypass),
    .byp_bits_i (byp_bits),
    .chip_clr_o (chip_clr),
    .pwr_o      (pwr)
  );

  assign synth_on = synth_active(st);

  radio_bw_timer #(
    .BW_STEP (BW_STEP)
  ) u_bw (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_1us),
    .synth_on_i (synth_on),
    .sel_i      (bw_dly_sel),
    .narrow_o   (bw_narrow)
  );

  assign osc_on  = pwr[PW_OSC];
  assign mult_on = pwr[PW_MULT];
  assign rx_pwr  = pwr[PW_RX];
  assign tx_pwr  = pwr[PW_TX];
  assign pa_pwr  = pwr[PW_PA];
  assign mode_o  = st;

endmodule

// File: rtl/radio_mode_chk.sv
module radio_mode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1us,
  input logic       pwr_on,
  input logic       bypass,
  input logic [3:0] mode_o,
  input logic       chip_clr,
  input logic       osc_on,
  input logic       mult_on,
  input logic       rx_pwr,
  input logic       tx_pwr,
  input logic       pa_pwr,
  input logic       bw_narrow
);

  // R1: off mode keeps everything cleared and unpowered
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'd0 && !bypass) |->
      (chip_clr && !osc_on && !mult_on && !rx_pwr && !tx_pwr && !pa_pwr));

  // R3: no mode change without a tick
  p_tick_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_1us |=> $stable(mode_o));

  // R4: idle never jumps into the transmit data states
  p_idle_no_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_o) == 4'd3) |-> !(mode_o inside {4'd7, 4'd8, 4'd9, 4'd10}));

  // R8: amplifier only with transmit path powered
  p_pa_needs_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_pwr && !bypass) |-> tx_pwr);

  // R8: amplifier is already off when the transmit path drops
  p_pa_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !$past(bypass) && $past(pwr_on) && $fell(tx_pwr)) |-> !$past(pa_pwr));

  // R13: narrow select only while the synthesizer runs
  p_narrow_synth_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bw_narrow |-> (mode_o >= 4'd6 && mode_o <= 4'd12));

endmodule

bind radio_mode_ctrl radio_mode_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_1us  (tick_1us),
  .pwr_on    (pwr_on),
  .bypass    (bypass),
  .mode_o    (mode_o),
  .chip_clr  (chip_clr),
  .osc_on    (osc_on),
  .mult_on   (mult_on),
  .rx_pwr    (rx_pwr),
  .tx_pwr    (tx_pwr),
  .pa_pwr    (pa_pwr),
  .bw_narrow (bw_narrow)
);

// File: tb/radio_mode_ctrl_tb.sv
module radio_mode_ctrl_tb_top;

  localparam int CLK_P = 10;
  localparam int NV    = 31;

  // {req[27:24], pwr xtal data pkt rx tx [23:18], ticks[17:10], mode[9:6], clr osc mult rx tx pa [5:0]}
  localparam logic [27:0] VEC [NV] = '{
    {4'd1,  6'b000000, 8'd2, 4'd0,  6'b100000},  // R1 off holds
    {4'd2,  6'b100000, 8'd1, 4'd1,  6'b010000},  // R2 power up
    {4'd2,  6'b100000, 8'd7, 4'd1,  6'b010000},  // R2 still settling
    {4'd2,  6'b100000, 8'd1, 4'd2,  6'b010000},  // R2 hold
    {4'd2,  6'b100000, 8'd2, 4'd2,  6'b010000},  // R2 hold waits
    {4'd2,  6'b110000, 8'd1, 4'd3,  6'b010000},  // R2 idle
    {4'd4,  6'b110011, 8'd2, 4'd3,  6'b010000},  // R4 both enables
    {4'd5,  6'b110001, 8'd1, 4'd6,  6'b010000},  // R5 arm
    {4'd5,  6'b110001, 8'd3, 4'd6,  6'b010000},  // R5 tx not yet
    {4'd5,  6'b110001, 8'd1, 4'd6,  6'b010010},  // R5 tx up
    {4'd6,  6'b111101, 8'd1, 4'd6,  6'b010010},  // R6 edge with pkt high
    {4'd6,  6'b111001, 8'd1, 4'd6,  6'b010010},  // R6 level only
    {4'd6,  6'b110001, 8'd1, 4'd6,  6'b010010},  // R6 low
    {4'd6,  6'b111001, 8'd1, 4'd7,  6'b010010},  // R6 edge
    {4'd7,  6'b111101, 8'd1, 4'd8,  6'b010011},  // R7 pa on
    {4'd7,  6'b111101, 8'd1, 4'd9,  6'b010011},  // R7 run
    {4'd7,  6'b111101, 8'd2, 4'd9,  6'b010011},  // R7 run holds
    {4'd8,  6'b111010, 8'd1, 4'd10, 6'b010010},  // R8 pa off first
    {4'd9,  6'b111010, 8'd1, 4'd3,  6'b010000},  // R9 one idle tick
    {4'd9,  6'b111010, 8'd1, 4'd11, 6'b011000},  // R9 turnaround
    {4'd10, 6'b111010, 8'd5, 4'd11, 6'b011000},  // R10 rx not yet
    {4'd10, 6'b111010, 8'd1, 4'd11, 6'b011100},  // R10 rx up
    {4'd10, 6'b111010, 8'd1, 4'd12, 6'b011100},  // R10 rx run
    {4'd10, 6'b111000, 8'd1, 4'd3,  6'b010000},  // R10 rx off
    {4'd11, 6'b101000, 8'd1, 4'd4,  6'b000000},  // R11 sleep
    {4'd11, 6'b101000, 8'd2, 4'd4,  6'b000000},  // R11 sleep holds
    {4'd11, 6'b111000, 8'd1, 4'd5,  6'b010000},  // R11 wake
    {4'd11, 6'b111000, 8'd7, 4'd5,  6'b010000},  // R11 still settling
    {4'd11, 6'b111000, 8'd1, 4'd3,  6'b010000},  // R11 back to idle
    {4'd5,  6'b111001, 8'd1, 4'd6,  6'b010000},  // R5 arm again
    {4'd12, 6'b011001, 8'd1, 4'd0,  6'b100000}   // R12 power loss
  };

  logic clk = 1'b0;
  logic rst_n, tick_1us, pwr_on, xtal_en, data_in, pkt_ctl, rx_en, tx_en, bypass;
  logic [1:0] bw_dly_sel;
  logic [4:0] byp_bits;
  logic chip_clr, osc_on, mult_on, rx_pwr, tx_pwr, pa_pwr, bw_narrow;
  logic [3:0] mode_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  radio_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .pwr_on(pwr_on),
    .xtal_en(xtal_en), .data_in(data_in), .pkt_ctl(pkt_ctl), .rx_en(rx_en),
    .tx_en(tx_en), .bw_dly_sel(bw_dly_sel), .bypass(bypass), .byp_bits(byp_bits),
    .chip_clr(chip_clr), .osc_on(osc_on), .mult_on(mult_on), .rx_pwr(rx_pwr),
    .tx_pwr(tx_pwr), .pa_pwr(pa_pwr), .bw_narrow(bw_narrow), .mode_o(mode_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_ticks(input int n);
    repeat (n) begin
      @(negedge clk) tick_1us = 1'b1;
      @(negedge clk) tick_1us = 1'b0;
      @(negedge clk);
    end
  endtask

  function automatic logic [5:0] outs();
    return {chip_clr, osc_on, mult_on, rx_pwr, tx_pwr, pa_pwr};
  endfunction

  task automatic go_idle();
    {pwr_on, xtal_en, data_in, pkt_ctl, rx_en, tx_en} = 6'b100000;
    do_ticks(1);
    do_ticks(8);
    xtal_en = 1'b1;
    do_ticks(1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_1us = 1'b0; bypass = 1'b0; byp_bits = 5'b0; bw_dly_sel = 2'd0;
    {pwr_on, xtal_en, data_in, pkt_ctl, rx_en, tx_en} = 6'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", {28'd0, mode_o}, 32'd0);
    chk("R1 reset outs", {26'd0, outs()}, {26'd0, 6'b100000});

    for (int i = 0; i < NV; i++) begin
      {pwr_on, xtal_en, data_in, pkt_ctl, rx_en, tx_en} = VEC[i][23:18];
      do_ticks(int'(VEC[i][17:10]));
      chk($sformatf("R%0d row %0d mode", VEC[i][27:24], i), {28'd0, mode_o}, {28'd0, VEC[i][9:6]});
      chk($sformatf("R%0d row %0d outs", VEC[i][27:24], i), {26'd0, outs()}, {26'd0, VEC[i][5:0]});
    end

    // R3: pins change but no tick arrives
    pwr_on = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3 no tick no move", {28'd0, mode_o}, 32'd0);
    go_idle();
    chk("R2 directed idle", {28'd0, mode_o}, 32'd3);

    // R13: bandwidth switch at code 1
    bw_dly_sel = 2'd1;
    rx_en = 1'b1;
    do_ticks(1);
    chk("R13 wide at start", {31'd0, bw_narrow}, 32'd0);
    do_ticks(49);
    chk("R13 wide at 49", {31'd0, bw_narrow}, 32'd0);
    chk("R10 run during wide", {28'd0, mode_o}, 32'd12);
    do_ticks(1);
    chk("R13 narrow at 50", {31'd0, bw_narrow}, 32'd1);
    rx_en = 1'b0;
    do_ticks(1);
    chk("R13 cleared when off", {31'd0, bw_narrow}, 32'd0);
    bw_dly_sel = 2'd0;
    rx_en = 1'b1;
    do_ticks(1);
    chk("R13 code 0 immediate", {31'd0, bw_narrow}, 32'd1);
    rx_en = 1'b0;
    do_ticks(1);

    // R14: bypass drives outputs from register bits
    bypass = 1'b1;
    byp_bits = 5'b10110;
    @(negedge clk);
    chk("R14 bypass pattern a", {27'd0, osc_on, mult_on, pa_pwr, rx_pwr, tx_pwr}, {27'd0, 5'b10110});
    byp_bits = 5'b01001;
    @(negedge clk);
    chk("R14 bypass pattern b", {27'd0, osc_on, mult_on, pa_pwr, rx_pwr, tx_pwr}, {27'd0, 5'b01001});
    bypass = 1'b0;
    @(negedge clk);
    chk("R14 bypass released", {26'd0, outs()}, {26'd0, 6'b010000});

    // R12 with R6: power loss and data edge on one tick
    tx_en = 1'b1;
    do_ticks(1);
    chk("R5 arm before collision", {28'd0, mode_o}, 32'd6);
    data_in = 1'b0;
    do_ticks(1);
    data_in = 1'b1;
    pwr_on  = 1'b0;
    do_ticks(1);
    chk("R12 power loss wins mode", {28'd0, mode_o}, 32'd0);
    chk("R12 power loss wins outs", {26'd0, outs()}, {26'd0, 6'b100000});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule